// File: doc/BRIEF.md
# Dual-Mode Sample FIFO with Status Flags

This block is a single-clock sample buffer that sits between a data producer and a burst reader. The producer pushes one word on every clock edge that has the write enable high. The reader pops words with its own read enable. Both ports run on the same clock, and each port has its own enable.

A mode input picks how the read side behaves. In standard mode the head word comes out one cycle after a read is requested. In fall-through mode the oldest word already sits on the output with a valid indication, and a read request moves on to the next word. A build parameter sets how the storage is organised. It can be deep and narrow, with words of the base width. It can also be wide, with words of twice that width and half the depth.

The block reports five flags, all computed from the registered occupancy count: empty, full, half full, almost full and almost empty. The almost-empty threshold is a run-time input. The flag goes high once the stored count is greater than that threshold. With the threshold set to the burst length minus one, the flag tells the reader that a complete burst can be read. A sticky overflow indicator records any write that was refused because the buffer was full.

Top module: `burst_fifo`

## Requirements
- R1: A synchronous active-low reset clears the pointers, the count and the overflow indicator. During and after reset, empty is 1, and full, half_full, almost_full, almost_empty and rd_valid are 0. rd_data is 0.
- R2: In standard mode (fwft_mode = 0), a read accepted at a clock edge places the oldest stored word on rd_data and raises rd_valid after that edge. Words come out in write order. Without an accepted read, rd_valid is 0 and rd_data keeps its value.
- R3: A write while full stores nothing and sets overflow. overflow then stays 1 until reset.
- R4: A read while empty moves no pointer and leaves the count at zero. rd_data keeps the last word read.
- R5: In fall-through mode (fwft_mode = 1), once a word is stored it appears on rd_data with rd_valid = 1 and no read request. A read moves the output to the next word. rd_valid equals "not empty".
- R6: empty is 1 exactly when the count is 0. full is 1 exactly when the count equals the configured depth.
- R7: half_full is 1 when the count is at least half the configured depth.
- R8: almost_full is 1 when the number of free entries (depth minus count) is at most the parameter AF_FREE.
- R9: almost_empty is 1 when the count is greater than the ae_thresh input. With ae_thresh = B-1, it rises exactly when B words can be read.
- R10: A write and a read accepted in the same cycle leave the count, and every flag that depends only on the count, unchanged.
- R11: With WIDE = 1, the configured depth is NARROW_DEPTH/2 words of 2*BASE_W bits, and every bit of a word is returned. With WIDE = 0, it is NARROW_DEPTH words of BASE_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| fwft_mode | input | 1 | 0 = standard read, 1 = fall-through read; change only while in reset |
| wr_en | input | 1 | Write enable; one word is taken per edge |
| wr_data | input | DW (BASE_W or 2*BASE_W) | Word to store |
| rd_en | input | 1 | Read enable |
| ae_thresh | input | CW = $clog2(DEPTH+1) | Almost-empty threshold |
| rd_data | output | DW | Output word |
| rd_valid | output | 1 | rd_data holds a newly read word (standard) or the head word (fall-through) |
| full | output | 1 | Count equals depth |
| half_full | output | 1 | Count is at least depth/2 |
| empty | output | 1 | Count is zero |
| almost_full | output | 1 | Free entries are at most AF_FREE |
| almost_empty | output | 1 | Count is greater than ae_thresh |
| overflow | output | 1 | Sticky: a write was refused while full |

## Verification
The bench builds the block with NARROW_DEPTH = 64, BASE_W = 9, WIDE = 1 and AF_FREE = 3, which gives 32 words of 18 bits. With this depth, full, overflow and every threshold crossing are reached within a few dozen cycles. The 18-bit words show that both halves of the wide organisation are kept. The same instance is reset into each read mode in turn. In each mode it runs directed fill, drain, empty-read and simultaneous-access cases, then random traffic with the write and read probabilities shifted by phase. That traffic also moves the almost-empty threshold across its whole 0..32 range.

// File: rtl/fifo_pkg.sv
// Package: shared types and sizing helpers for the dual-mode sample FIFO.
// Assumes: callers pass a narrow depth that is even and at least 4.
package fifo_pkg;

    typedef enum logic {
        RD_STANDARD    = 1'b0,
        RD_FALLTHROUGH = 1'b1
    } rd_mode_e;

    // Number of words for the chosen organisation.
    function automatic int org_depth(input int narrow_depth, input int wide);
        return (wide != 0) ? narrow_depth / 2 : narrow_depth;
    endfunction

    // Word width for the chosen organisation.
    function automatic int org_width(input int base_w, input int wide);
        return (wide != 0) ? 2 * base_w : base_w;
    endfunction

endpackage

// File: rtl/fifo_store.sv
// Module: fifo_store
// Holds the storage array and the write/read pointers, and presents the
// head word without a register.
// Assumes: push and pop arrive already qualified against full and empty,
// and DEPTH >= 2.
module fifo_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 18,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] head_data
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;

    // The pointer wrap rule depends on whether the depth is a power of two.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
            assign wptr_nx = wptr + 1'b1;
            assign rptr_nx = rptr + 1'b1;
        end else begin : g_cmp_wrap
            assign wptr_nx = (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            assign rptr_nx = (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
        end
    endgenerate

    // Advance each pointer on an accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr_nx;
            if (pop)  rptr <= rptr_nx;
        end
    end

    // Write the incoming word into the slot the write pointer selects.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    assign head_data = mem[rptr];

endmodule

// File: rtl/fifo_occupancy.sv
// Module: fifo_occupancy
// Keeps the registered word count and derives all five status flags and
// the sticky overflow indicator from it.
// Assumes: push and pop are already qualified; wr_req is the raw write enable.
module fifo_occupancy #(
    parameter int DEPTH   = 32,
    parameter int AF_FREE = 3,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          wr_req,
    input  logic [CW-1:0] ae_thresh,
    output logic          full,
    output logic          half_full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty,
    output logic          overflow
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);
    localparam logic [CW-1:0] AF_C    = CW'(AF_FREE);

    logic [CW-1:0] count;
    logic [CW-1:0] free_slots;

    // Track occupancy; a push and a pop in the same cycle cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Latch any write that was refused because the buffer was full.
    always_ff @(posedge clk) begin
        if (!rst_n) overflow <= 1'b0;
        else if (wr_req && full) overflow <= 1'b1;
    end

    // Derive the flags from the registered count.
    always_comb begin
        free_slots   = DEPTH_C - count;
        full         = (count == DEPTH_C);
        empty        = (count == '0);
        half_full    = (count >= HALF_C);
        almost_full  = (free_slots <= AF_C);
        almost_empty = (count > ae_thresh);
    end

endmodule

// File: rtl/fifo_read_stage.sv
// Module: fifo_read_stage
// Builds the read-side output for the selected mode: a registered word in
// standard mode, or the live head word in fall-through mode.
// Assumes: mode stays fixed outside reset; pop is already qualified.
module fifo_read_stage
    import fifo_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rd_mode_e      mode,
    input  logic          pop,
    input  logic          empty,
    input  logic [DW-1:0] head_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    logic [DW-1:0] last_word;
    logic          popped_q;

    // Capture the word consumed by each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_word <= '0;
            popped_q  <= 1'b0;
        end else begin
            popped_q <= pop;
            if (pop) last_word <= head_data;
        end
    end

    // Select what the reader sees for the active mode.
    always_comb begin
        if (mode == RD_FALLTHROUGH) begin
            rd_data  = empty ? last_word : head_data;
            rd_valid = !empty;
        end else begin
            rd_data  = last_word;
            rd_valid = popped_q;
        end
    end

endmodule

// File: rtl/burst_fifo.sv
// Module: burst_fifo (top)
// Single-clock sample FIFO with standard or fall-through reads, five status
// flags and a sticky overflow indicator. WIDE selects narrow/deep or
// wide/shallow organisation.
// Assumes: one shared clock; fwft_mode changes only while rst_n is low.
module burst_fifo
    import fifo_pkg::*;
#(
    parameter int NARROW_DEPTH = 1024,
    parameter int BASE_W       = 9,
    parameter int WIDE         = 0,
    parameter int AF_FREE      = 16,
    localparam int DEPTH       = org_depth(NARROW_DEPTH, WIDE),
    localparam int DW          = org_width(BASE_W, WIDE),
    localparam int CW          = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_mode,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [CW-1:0] ae_thresh,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          full,
    output logic          half_full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty,
    output logic          overflow
);

    logic          push, pop;
    logic [DW-1:0] head_data;
    rd_mode_e      mode;

    // Accept an access only when it can complete.
    assign push = wr_en && !full;
    assign pop  = rd_en && !empty;
    assign mode = rd_mode_e'(fwft_mode);

    fifo_store #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .wr_data   (wr_data),
        .head_data (head_data)
    );

    fifo_occupancy #(
        .DEPTH   (DEPTH),
        .AF_FREE (AF_FREE)
    ) u_occ (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (push),
        .pop          (pop),
        .wr_req       (wr_en),
        .ae_thresh    (ae_thresh),
        .full         (full),
        .half_full    (half_full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty),
        .overflow     (overflow)
    );

    fifo_read_stage #(
        .DW (DW)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .pop       (pop),
        .empty     (empty),
        .head_data (head_data),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/burst_fifo_chk.sv
// Module: burst_fifo_chk
// Port-level temporal checks for burst_fifo, attached with bind.
// Assumes: connected by name to the top-level ports.
module burst_fifo_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fwft_mode,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid,
    input logic          full,
    input logic          half_full,
    input logic          empty,
    input logic          almost_full,
    input logic          overflow
);

    // R1: one cycle in reset leaves the buffer empty and clean.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !overflow && !rd_valid));

    // R3: a write against a full buffer raises overflow.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> overflow);

    // R3: overflow is sticky.
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R4: a lone read against an empty buffer changes nothing visible.
    assert_empty_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data)));

    // R5: in fall-through mode valid tracks non-empty.
    assert_fwft_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fwft_mode |-> (rd_valid == !empty));

    // R6: full and empty never hold together.
    assert_full_empty_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R7: a full buffer is also half full.
    assert_full_implies_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half_full);

    // R10: a balanced access leaves count-driven flags steady.
    assert_balanced_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !full && !empty) |=>
            $stable({full, half_full, empty, almost_full}));

endmodule

bind burst_fifo burst_fifo_chk #(.DW(DW)) u_chk (.*);

// File: tb/burst_fifo_tb.sv
module burst_fifo_tb;

    localparam int NARROW = 64;
    localparam int BASEW  = 9;
    localparam int WIDEP  = 1;
    localparam int AFF    = 3;
    localparam int DEPTH  = 32;
    localparam int DW     = 18;
    localparam int CW     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [CW-1:0] ae_thresh = CW'(7);
    logic [DW-1:0] rd_data;
    logic          rd_valid, full, half_full, empty, almost_full, almost_empty, overflow;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic [DW-1:0] mq[$];
    logic [DW-1:0] m_last;
    bit            m_pop_q;
    bit            m_ovf;

    always #2 clk = ~clk;

    burst_fifo #(
        .NARROW_DEPTH (NARROW),
        .BASE_W       (BASEW),
        .WIDE         (WIDEP),
        .AF_FREE      (AFF)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fwft_mode    (fwft_mode),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .ae_thresh    (ae_thresh),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .full         (full),
        .half_full    (half_full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty),
        .overflow     (overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_data();
        if (fwft_mode && mq.size() > 0) return mq[0];
        return m_last;
    endfunction

    function automatic bit exp_valid();
        if (fwft_mode) return mq.size() > 0;
        return m_pop_q;
    endfunction

    // Compare every output against the model.
    task automatic check_all();
        int n = mq.size();
        check(fwft_mode ? "R5 rd_data" : "R2 rd_data", 32'(rd_data), 32'(exp_data()));
        check(fwft_mode ? "R5 rd_valid" : "R2 rd_valid", 32'(rd_valid), 32'(exp_valid()));
        check("R6 empty", 32'(empty), 32'(n == 0));
        check("R6 full", 32'(full), 32'(n == DEPTH));
        check("R7 half_full", 32'(half_full), 32'(n >= DEPTH / 2));
        check("R8 almost_full", 32'(almost_full), 32'((DEPTH - n) <= AFF));
        check("R9 almost_empty", 32'(almost_empty), 32'(n > int'(ae_thresh)));
        check("R3 overflow", 32'(overflow), 32'(m_ovf));
    endtask

    // One clock: drive at negedge, advance model, check at next negedge.
    task automatic cycle(input bit w, input logic [DW-1:0] d, input bit r);
        bit push_ok, pop_ok;
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        push_ok = w && (mq.size() < DEPTH);
        pop_ok  = r && (mq.size() > 0);
        if (w && mq.size() == DEPTH) m_ovf = 1'b1;
        if (pop_ok) begin
            m_last = mq[0];
            void'(mq.pop_front());
        end
        if (push_ok) mq.push_back(d);
        m_pop_q = pop_ok;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check_all();
    endtask

    task automatic do_reset(input bit mode);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; fwft_mode = mode;
        repeat (3) @(posedge clk);
        @(negedge clk);
        mq.delete(); m_last = '0; m_pop_q = 1'b0; m_ovf = 1'b0;
        check("R1 empty", 32'(empty), 32'd1);
        check("R1 almost_empty", 32'(almost_empty), 32'd0);
        check("R1 full/half/af", 32'({full, half_full, almost_full}), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 rd_data", 32'(rd_data), 32'd0);
        check("R1 overflow", 32'(overflow), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic run_mode(input bit mode);
        do_reset(mode);
        ae_thresh = CW'(7);
        // R4: read on empty buffer.
        cycle(1'b0, '0, 1'b1);
        check("R4 empty read keeps empty", 32'(empty), 32'd1);
        // R9: burst of 8 becomes readable exactly at 8 words.
        for (int i = 0; i < 8; i++) begin
            cycle(1'b1, DW'(18'h2A000 + i), 1'b0);
            check("R9 burst ready", 32'(almost_empty), 32'(i == 7));
        end
        // R11: fill to the wide-organisation depth with full-width words.
        for (int i = 8; i < DEPTH; i++) cycle(1'b1, DW'(18'h3FF00 | i), 1'b0);
        check("R11 full at NARROW/2 words", 32'(full), 32'd1);
        // R3: write against full is dropped.
        cycle(1'b1, DW'(18'h15555), 1'b0);
        check("R3 overflow set", 32'(overflow), 32'd1);
        // R10: simultaneous access on a partly filled buffer.
        cycle(1'b0, '0, 1'b1);
        cycle(1'b1, DW'(18'h0ABCD), 1'b1);
        check("R10 balanced keeps not-full", 32'(full), 32'd0);
        // Drain completely, checking order (R2/R5) each cycle.
        while (mq.size() > 0) cycle(1'b0, '0, 1'b1);
        check("R11 last word all bits", 32'(rd_data), 32'(18'h0ABCD));
        cycle(1'b0, '0, 1'b1);
        check("R4 hold last word", 32'(rd_data), 32'(18'h0ABCD));
        check("R3 overflow sticky", 32'(overflow), 32'd1);
        // Random traffic in phases of shifting write/read bias.
        for (int ph = 0; ph < 6; ph++) begin
            int pw = (ph % 2 == 0) ? 80 : 30;
            int pr = (ph % 2 == 0) ? 35 : 85;
            for (int k = 0; k < 120; k++) begin
                if ($urandom % 16 == 0) ae_thresh = CW'($urandom % (DEPTH + 1));
                cycle(($urandom % 100) < pw, DW'($urandom), ($urandom % 100) < pr);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        run_mode(1'b0);
        run_mode(1'b1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule